// File: doc/BRIEF.md
# Configuration byte readback controller

This block sits between a small processor core and its program memory. Software opens a short readback window by writing a self-programming control register with both its store-enable bit and its lock-select bit set. While that window is open, the next program-memory load whose address is in the range 0x0000 to 0x0003 returns a non-volatile configuration byte in place of flash data. The four bytes are the fuse low byte, the lock byte, the extended fuse byte and the fuse high byte. Any load outside that range returns flash data.

The window is counted in clock cycles. It closes after the first load, or after three cycles with no load. A store-only arm, with just the store-enable bit set, stays open for four cycles or until a store strobe arrives. While the EEPROM reports a write in progress, the control register ignores writes, so nothing can be armed. The configuration storage is modelled as input ports that carry "programmed" flags. The block inverts those flags, so a programmed bit reads as 0.

Top module: `cfg_readback_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, and a load returns `flash_rdata`.
- R2: The control register holds the store-enable flag at bit 0 and the lock-select flag at bit 3; all other bits read 0. A write that sets both bits arms a configuration window. Lock-select is only kept when store-enable is written as 1 in the same write.
- R3: In the first three cycles after the arming write, a load with address 0x0000 returns the fuse low byte, 0x0001 the lock byte, 0x0002 the extended fuse byte and 0x0003 the fuse high byte.
- R4: A configuration load closes the window. The control register reads 0x00 on the next cycle, and later loads return flash data.
- R5: If no load arrives in the three cycles after arming, both bits clear, and a load in the fourth cycle returns flash data.
- R6: A store-only arm (0x01) clears itself after four cycles without a store strobe, or on the cycle after a store strobe.
- R7: Each configuration input flag set to 1 (programmed) reads back as 0, and each flag at 0 reads back as 1.
- R8: The lock byte reads as {1,1,lock_prog[5:0] inverted}, with boot lock bits at positions 5 down to 2 and lock bits at 1 and 0. The extended fuse byte reads as {4'b1111, fuse_ext_prog inverted}.
- R9: While `ee_busy` is 1, control register writes are ignored. The register keeps its value and loads return flash data.
- R10: During an open window, a load whose address is outside 0x0000 to 0x0003 returns flash data and still closes the window.
- R11: With no window open, every load returns `flash_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| ld_req | input | 1 | Program-memory load strobe |
| ld_addr | input | 16 | Load pointer address |
| flash_rdata | input | 8 | Program-memory data for the current load |
| ld_data | output | 8 | Load result (combinational) |
| st_req | input | 1 | Program-memory store strobe |
| ee_busy | input | 1 | EEPROM write in progress |
| fuse_lo_prog | input | 8 | Fuse low byte, 1 = programmed |
| fuse_hi_prog | input | 8 | Fuse high byte, 1 = programmed |
| fuse_ext_prog | input | 4 | Extended fuse bits, 1 = programmed |
| lock_prog | input | 6 | Lock bits (boot 12,11,02,01, lock 2,1), 1 = programmed |

## Verification
The hardest situation to reach is the exact edge of each timeout: a load in the third cycle must still hit, a load in the fourth must miss, and a store-only arm must survive exactly four cycles. The bench's vector table sets a wait of zero to three cycles between the arming write and the load. Directed tests then poll the control register one cycle at a time after a store-only arm. Loads at addresses whose low two bits are zero but whose high bits are not must also miss, and a table vector covers that case.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;

  localparam int REG_W   = 8;
  localparam int EN_BIT  = 0;
  localparam int SEL_BIT = 3;

  typedef enum logic [1:0] {
    SLOT_FUSE_LO  = 2'd0,
    SLOT_LOCK     = 2'd1,
    SLOT_FUSE_EXT = 2'd2,
    SLOT_FUSE_HI  = 2'd3
  } slot_e;

  // programmed flags read back inverted
  function automatic logic [7:0] byte_from_prog(input logic [7:0] prog);
    return ~prog;
  endfunction

  // unassigned upper positions read as unprogrammed
  function automatic logic [7:0] lock_byte(input logic [5:0] prog);
    return {2'b11, ~prog};
  endfunction

  function automatic logic [7:0] ext_byte(input logic [3:0] prog);
    return {4'hF, ~prog};
  endfunction

  function automatic logic [REG_W-1:0] reg_image(input logic en, input logic sel);
    logic [REG_W-1:0] r;
    r = '0;
    r[EN_BIT]  = en;
    r[SEL_BIT] = sel;
    return r;
  endfunction

endpackage

// File: rtl/cfgrb_arm_timer.sv
module cfgrb_arm_timer #(
  parameter int LD_WIN = 3,
  parameter int ST_WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_accept,
  input  logic wd_en,
  input  logic wd_sel,
  input  logic ld_req,
  input  logic st_req,
  output logic arm_en,
  output logic arm_sel,
  output logic ld_timeout,
  output logic st_timeout,
  output logic consume
);

  localparam int MAX_WIN = (LD_WIN > ST_WIN) ? LD_WIN : ST_WIN;
  localparam int CNT_W   = $clog2(MAX_WIN + 1);
  localparam logic [CNT_W-1:0] LD_LAST = CNT_W'(LD_WIN - 1);
  localparam logic [CNT_W-1:0] ST_LAST = CNT_W'(ST_WIN - 1);

  logic [CNT_W-1:0] cnt;
  logic             cfg_win;
  logic             st_win;

  assign cfg_win    = arm_en & arm_sel;
  assign st_win     = arm_en & ~arm_sel;
  assign consume    = (cfg_win & ld_req) | (arm_en & st_req);
  assign ld_timeout = cfg_win & ~ld_req & ~st_req & (cnt == LD_LAST);
  assign st_timeout = st_win & ~st_req & (cnt == ST_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_en  <= 1'b0;
      arm_sel <= 1'b0;
      cnt     <= '0;
    end else if (wr_accept) begin
      arm_en  <= wd_en;
      arm_sel <= wd_en & wd_sel;
      cnt     <= '0;
    end else if (consume | ld_timeout | st_timeout) begin
      arm_en  <= 1'b0;
      arm_sel <= 1'b0;
      cnt     <= '0;
    end else if (arm_en) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cfgrb_load_mux.sv
module cfgrb_load_mux
  import cfgrb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              cfg_win,
  input  logic              ld_req,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        flash_rdata,
  input  logic [7:0]        fuse_lo_prog,
  input  logic [7:0]        fuse_hi_prog,
  input  logic [3:0]        fuse_ext_prog,
  input  logic [5:0]        lock_prog,
  output logic              cfg_hit,
  output logic [7:0]        ld_data
);

  logic  upper_zero;
  slot_e slot;
  logic [7:0] cfg_byte;

  assign upper_zero = (ld_addr[ADDR_W-1:2] == '0);
  assign slot       = slot_e'(ld_addr[1:0]);
  assign cfg_hit    = cfg_win & ld_req & upper_zero;

  always_comb begin
    unique case (slot)
      SLOT_FUSE_LO:  cfg_byte = byte_from_prog(fuse_lo_prog);
      SLOT_LOCK:     cfg_byte = lock_byte(lock_prog);
      SLOT_FUSE_EXT: cfg_byte = ext_byte(fuse_ext_prog);
      default:       cfg_byte = byte_from_prog(fuse_hi_prog);
    endcase
  end

  assign ld_data = cfg_hit ? cfg_byte : flash_rdata;

endmodule

// File: rtl/cfg_readback_ctrl.sv
module cfg_readback_ctrl
  import cfgrb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LD_WIN = 3,
  parameter int ST_WIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ld_req,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        flash_rdata,
  output logic [7:0]        ld_data,
  input  logic              st_req,
  input  logic              ee_busy,
  input  logic [7:0]        fuse_lo_prog,
  input  logic [7:0]        fuse_hi_prog,
  input  logic [3:0]        fuse_ext_prog,
  input  logic [5:0]        lock_prog
);

  // named internal events for the checker
  logic wr_accept;
  logic wr_blocked;
  logic arm_en;
  logic arm_sel;
  logic cfg_win;
  logic cfg_hit;
  logic ld_timeout;
  logic st_timeout;
  logic consume;

  assign wr_accept  = reg_wr & ~ee_busy;
  assign wr_blocked = reg_wr & ee_busy;
  assign cfg_win    = arm_en & arm_sel;

  cfgrb_arm_timer #(
    .LD_WIN (LD_WIN),
    .ST_WIN (ST_WIN)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_accept  (wr_accept),
    .wd_en      (reg_wdata[EN_BIT]),
    .wd_sel     (reg_wdata[SEL_BIT]),
    .ld_req     (ld_req),
    .st_req     (st_req),
    .arm_en     (arm_en),
    .arm_sel    (arm_sel),
    .ld_timeout (ld_timeout),
    .st_timeout (st_timeout),
    .consume    (consume)
  );

  cfgrb_load_mux #(
    .ADDR_W (ADDR_W)
  ) u_mux (
    .cfg_win       (cfg_win),
    .ld_req        (ld_req),
    .ld_addr       (ld_addr),
    .flash_rdata   (flash_rdata),
    .fuse_lo_prog  (fuse_lo_prog),
    .fuse_hi_prog  (fuse_hi_prog),
    .fuse_ext_prog (fuse_ext_prog),
    .lock_prog     (lock_prog),
    .cfg_hit       (cfg_hit),
    .ld_data       (ld_data)
  );

  assign reg_rdata = reg_image(arm_en, arm_sel);

endmodule

// File: rtl/cfg_readback_ctrl_chk.sv
module cfg_readback_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int LD_WIN = 3,
  parameter int ST_WIN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        reg_rdata,
  input logic              ld_req,
  input logic [ADDR_W-1:0] ld_addr,
  input logic [7:0]        flash_rdata,
  input logic [7:0]        ld_data,
  input logic [5:0]        lock_prog,
  input logic              reg_wr,
  input logic              ee_busy,
  input logic              wr_accept,
  input logic              cfg_hit
);

  logic [7:0] ck_cnt;
  logic       win_cfg;
  logic       win_st;

  assign win_cfg = reg_rdata[0] & reg_rdata[3];
  assign win_st  = reg_rdata[0] & ~reg_rdata[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ck_cnt <= '0;
    else if (wr_accept)       ck_cnt <= '0;
    else if (reg_rdata[0])    ck_cnt <= ck_cnt + 8'd1;
    else                      ck_cnt <= '0;
  end

  AST_HIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hit && !wr_accept) |=> (reg_rdata == 8'h00)); // R4

  AST_LD_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_cfg |-> (ck_cnt < 8'(LD_WIN))); // R5

  AST_ST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_st |-> (ck_cnt < 8'(ST_WIN))); // R6

  AST_BUSY_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && ee_busy && reg_rdata == 8'h00) |=> (reg_rdata == 8'h00)); // R9

  AST_IDLE_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !reg_rdata[0]) |-> (ld_data == flash_rdata)); // R11

  AST_LOCK_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cfg && ld_req && ld_addr == ADDR_W'(1)) |-> (ld_data == {2'b11, ~lock_prog})); // R8

  AST_REG_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7:4] == 4'h0) && (reg_rdata[2:1] == 2'b00)); // R2

endmodule

bind cfg_readback_ctrl cfg_readback_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .LD_WIN (LD_WIN),
  .ST_WIN (ST_WIN)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_rdata   (reg_rdata),
  .ld_req      (ld_req),
  .ld_addr     (ld_addr),
  .flash_rdata (flash_rdata),
  .ld_data     (ld_data),
  .lock_prog   (lock_prog),
  .reg_wr      (reg_wr),
  .ee_busy     (ee_busy),
  .wr_accept   (wr_accept),
  .cfg_hit     (cfg_hit)
);

// File: tb/cfg_readback_ctrl_bench.sv
`timescale 1ns/1ps
module cfg_readback_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        ld_req = 1'b0;
  logic [15:0] ld_addr = '0;
  logic [7:0]  flash_rdata = '0;
  logic [7:0]  ld_data;
  logic        st_req = 1'b0;
  logic        ee_busy = 1'b0;
  logic [7:0]  fuse_lo_prog = '0;
  logic [7:0]  fuse_hi_prog = '0;
  logic [3:0]  fuse_ext_prog = '0;
  logic [5:0]  lock_prog = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cfg_readback_ctrl u_cfg_readback_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ld_req(ld_req), .ld_addr(ld_addr),
    .flash_rdata(flash_rdata), .ld_data(ld_data), .st_req(st_req),
    .ee_busy(ee_busy), .fuse_lo_prog(fuse_lo_prog), .fuse_hi_prog(fuse_hi_prog),
    .fuse_ext_prog(fuse_ext_prog), .lock_prog(lock_prog)
  );

  typedef struct packed {
    logic [7:0]  fl;
    logic [7:0]  fh;
    logic [3:0]  ex;
    logic [5:0]  lk;
    logic [15:0] addr;
    logic [2:0]  wait_cyc;
    logic [7:0]  flash;
    logic [7:0]  exp;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{8'h00, 8'h00, 4'h0, 6'h00, 16'h0000, 3'd0, 8'h5A, 8'hFF}, // R3 R7 fuse low
    '{8'h0F, 8'h00, 4'h0, 6'h00, 16'h0000, 3'd1, 8'h5A, 8'hF0}, // R7
    '{8'h00, 8'h00, 4'h0, 6'h3F, 16'h0001, 3'd2, 8'h5A, 8'hC0}, // R8 third cycle
    '{8'h00, 8'h00, 4'h0, 6'h05, 16'h0001, 3'd0, 8'h5A, 8'hFA}, // R8
    '{8'h00, 8'h00, 4'h6, 6'h00, 16'h0002, 3'd1, 8'h5A, 8'hF9}, // R8 ext
    '{8'h00, 8'hA5, 4'h0, 6'h00, 16'h0003, 3'd2, 8'h5A, 8'h5A}, // R3 fuse high
    '{8'h00, 8'h00, 4'h0, 6'h00, 16'h0004, 3'd0, 8'h3C, 8'h3C}, // R10
    '{8'h00, 8'h00, 4'h0, 6'h00, 16'h0100, 3'd0, 8'h77, 8'h77}, // R10 high bits
    '{8'h00, 8'h00, 4'h0, 6'h00, 16'h0000, 3'd3, 8'h11, 8'h11}  // R5 timeout
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_load(input logic [15:0] a, input logic [7:0] fl, input string req,
                         input logic [7:0] exp);
    ld_req = 1'b1; ld_addr = a; flash_rdata = fl;
    #1;
    chk(req, ld_data, exp);
    @(posedge clk); @(negedge clk);
    ld_req = 1'b0; ld_addr = '0;
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reg", reg_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reg after release", reg_rdata, 8'h00);
    do_load(16'h0000, 8'hA3, "R1 load", 8'hA3);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      fuse_lo_prog = VEC[i].fl; fuse_hi_prog = VEC[i].fh;
      fuse_ext_prog = VEC[i].ex; lock_prog = VEC[i].lk;
      wr_reg(8'h09);
      if (VEC[i].wait_cyc == 3'd0) chk("R2 armed", reg_rdata, 8'h09);
      repeat (int'(VEC[i].wait_cyc)) @(negedge clk);
      do_load(VEC[i].addr, VEC[i].flash, "R3 vector", VEC[i].exp);
      chk("R4 closed", reg_rdata, 8'h00);
    end

    // R4 a later load after a hit returns flash
    fuse_lo_prog = 8'h00;
    wr_reg(8'h09);
    do_load(16'h0000, 8'h22, "R4 hit", 8'hFF);
    do_load(16'h0000, 8'h33, "R4 after hit", 8'h33);

    // R2 lock-select without store-enable is not kept
    wr_reg(8'h08);
    chk("R2 sel alone", reg_rdata, 8'h00);

    // R5 register clears exactly after three idle cycles
    wr_reg(8'h09);
    @(negedge clk); @(negedge clk);
    chk("R5 still armed", reg_rdata, 8'h09);
    @(negedge clk);
    chk("R5 cleared", reg_rdata, 8'h00);

    // R6 store-only timeout after four cycles
    wr_reg(8'h01);
    chk("R6 armed", reg_rdata, 8'h01);
    repeat (3) @(negedge clk);
    chk("R6 cycle four", reg_rdata, 8'h01);
    @(negedge clk);
    chk("R6 timeout", reg_rdata, 8'h00);

    // R6 store strobe closes early
    wr_reg(8'h01);
    st_req = 1'b1;
    @(posedge clk); @(negedge clk);
    st_req = 1'b0;
    chk("R6 store", reg_rdata, 8'h00);

    // R9 EEPROM busy blocks writes
    ee_busy = 1'b1;
    wr_reg(8'h09);
    chk("R9 reg", reg_rdata, 8'h00);
    do_load(16'h0001, 8'h44, "R9 load", 8'h44);
    ee_busy = 1'b0;

    // R11 no window
    do_load(16'h0003, 8'h55, "R11 load", 8'h55);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule